// File: doc/BRIEF.md
# Serial Flash Slave with Switchable Lane Width

This block is the device side of a serial memory link. A host frames each command with an active-low chip select. The host sends bytes on an 8-line IO bus, and the block samples that bus on the rising edge of the serial clock. After power-on reset the link carries one bit per clock on lane 0. A host holding write permission can switch the link to octal width. From then on every byte, opcode bytes included, moves in a single clock on all eight lanes. A software reset opcode returns the link to single-lane width.

The block decodes five commands:
- write enable, which sets a write-permission latch;
- octal select;
- page program, with a 4-byte address;
- streaming read, with a 4-byte address and eight dummy clocks;
- software reset.

Storage is an internal byte array whose depth is a parameter. The IO bus is split into an input vector, an output vector and a per-lane output enable, so a pad ring can build the bidirectional pins. The link is a plain serial protocol and has no back-pressure. A read keeps producing bytes for as long as chip select stays low.

Top module: `sfl_slave`

## Requirements
- R1: After `rst_n` is released, `io_oe` is 0, the link is in single-lane width and the write-permission latch is clear.
- R2: While `cs_n` is high, `io_oe` is 0 in the same cycle. Raising `cs_n` abandons any partial command, and the next low period starts with a fresh opcode byte.
- R3: In single-lane width a byte is taken MSB first from `io_in[0]`, one bit per rising edge. Opcode 0x06 sets the write-permission latch.
- R4: Opcode 0xE8 switches to octal width only while the latch is set, and it clears the latch. Without the latch it has no effect. In octal width each rising edge takes one whole byte from `io_in[7:0]`.
- R5: Opcode 0x02 with the latch set takes four address bytes, MSB first, and then writes each data byte at the address. The low 8 bits of the address advance and wrap inside the 256-byte page. Without the latch nothing is written.
- R6: When `cs_n` rises after an accepted 0x02 command, the write-permission latch clears.
- R7: Opcode 0x03 takes four address bytes MSB first, then 8 dummy clocks. The first data output is valid after the 8th dummy edge. In single-lane width the data goes out MSB first on `io_out[0]` with `io_oe` = 0x01. In octal width it goes out one byte per clock on `io_out[7:0]` with `io_oe` = 0xFF.
- R8: A read streams sequential bytes without limit while `cs_n` stays low. The address wraps from the top of the array to 0, and address bits above the array width are ignored.
- R9: Opcode 0x99 returns the link to single-lane width and clears the write-permission latch.
- R10: In single-lane width `io_oe[7:1]` is never asserted.
- R11: An unknown opcode is ignored, together with every further byte of the same low period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Serial clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Chip select, active low; frames each command |
| io_in | input | 8 | Input value of the IO lanes |
| io_out | output | 8 | Output value of the IO lanes during read data |
| io_oe | output | 8 | Per-lane output enable |

## Verification
The bench drives each bit or byte at a falling edge, and the design takes it on the next rising edge. The timing of each result is as follows:
- A single-lane byte completes on its 8th edge; an octal byte completes on its only edge.
- A program write lands on the edge that completes its data byte.
- Read data is valid after the 8th dummy edge. The next bit (single-lane) or byte (octal) follows each edge after that.
- `io_oe` drops together with a rising `cs_n`, with no clock delay.

The bench samples `io_out` and `io_oe` at the falling edge that follows the edge producing them. It checks the release of the output enables just after raising `cs_n`. Outcomes that leave nothing on the pins (latch state, width, dropped writes) are read back through a later read command.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 8;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_OCTAL = 8'hE8;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_SWRST = 8'h99;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_RDATA,
    ST_PDATA,
    ST_SKIP
  } sfl_state_e;
endpackage

// File: rtl/sfl_lane_rx.sv
// Gathers input bytes: eight bits on lane 0 MSB first, or one byte per edge.
module sfl_lane_rx
  import sfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              octal,
  input  logic [LANES-1:0]  io_in,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CW = $clog2(BYTE_W);

  logic [BYTE_W-2:0] sh_q;
  logic [CW-1:0]     bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (cs_n) begin
      bit_q <= '0;
    end else begin
      sh_q  <= {sh_q[BYTE_W-3:0], io_in[0]};
      bit_q <= bit_q + CW'(1);
    end
  end

  assign byte_val = octal ? io_in : {sh_q, io_in[0]};
  assign byte_vld = !cs_n && (octal || bit_q == CW'(BYTE_W - 1));
endmodule

// File: rtl/sfl_lane_tx.sv
// Drives read data: one bit per edge on lane 0, or one byte per edge.
module sfl_lane_tx
  import sfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              octal,
  input  logic              active,
  input  logic              load,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              fetch,
  output logic [LANES-1:0]  io_out,
  output logic [LANES-1:0]  io_oe
);
  localparam int CW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] osh_q;
  logic [CW-1:0]     obit_q;
  logic              shifting;

  assign shifting = active && !cs_n;
  assign fetch    = load || (shifting && (octal || obit_q == CW'(BYTE_W - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osh_q  <= '0;
      obit_q <= '0;
    end else if (fetch) begin
      osh_q  <= rd_byte;
      obit_q <= '0;
    end else if (shifting) begin
      osh_q  <= {osh_q[BYTE_W-2:0], 1'b0};
      obit_q <= obit_q + CW'(1);
    end
  end

  assign io_out = octal ? osh_q : {{(LANES-1){1'b0}}, osh_q[BYTE_W-1]};
  assign io_oe  = !shifting ? '0 : (octal ? '1 : LANES'(1));
endmodule

// File: rtl/sfl_store.sv
// Byte array: synchronous write, combinational read.
module sfl_store
  import sfl_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfl_ctrl.sv
// Command decoder: opcode, address, dummy, data phases; width and write latch.
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int DUMMY_CLKS = 8,
  localparam int AW        = $clog2(DEPTH),
  localparam int DCW       = (DUMMY_CLKS > 1) ? $clog2(DUMMY_CLKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              fetch,
  output sfl_state_e        state,
  output logic              octal,
  output logic              wel,
  output logic [AW-1:0]     addr,
  output logic              mem_we,
  output logic              load,
  output logic              active
);
  logic [1:0]     acnt_q;
  logic [DCW-1:0] dcnt_q;
  logic           is_read_q;
  logic           prog_armed_q;
  logic           last_dummy;

  assign last_dummy = (state == ST_DUMMY) && !cs_n && (dcnt_q == DCW'(DUMMY_CLKS - 1));
  assign load       = last_dummy;
  assign active     = (state == ST_RDATA);
  assign mem_we     = (state == ST_PDATA) && byte_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_OPC;
      octal        <= 1'b0;
      wel          <= 1'b0;
      addr         <= '0;
      acnt_q       <= '0;
      dcnt_q       <= '0;
      is_read_q    <= 1'b0;
      prog_armed_q <= 1'b0;
    end else if (cs_n) begin
      state  <= ST_OPC;
      acnt_q <= '0;
      dcnt_q <= '0;
      if (prog_armed_q) begin
        wel          <= 1'b0;
        prog_armed_q <= 1'b0;
      end
    end else begin
      unique case (state)
        ST_OPC: if (byte_vld) begin
          acnt_q <= '0;
          unique case (byte_val)
            OP_WREN: begin
              wel   <= 1'b1;
              state <= ST_SKIP;
            end
            OP_OCTAL: begin
              if (wel) begin
                octal <= 1'b1;
                wel   <= 1'b0;
              end
              state <= ST_SKIP;
            end
            OP_SWRST: begin
              octal <= 1'b0;
              wel   <= 1'b0;
              state <= ST_SKIP;
            end
            OP_READ: begin
              is_read_q <= 1'b1;
              state     <= ST_ADDR;
            end
            OP_PROG: begin
              if (wel) begin
                is_read_q    <= 1'b0;
                prog_armed_q <= 1'b1;
                state        <= ST_ADDR;
              end else begin
                state <= ST_SKIP;
              end
            end
            default: state <= ST_SKIP;
          endcase
        end
        ST_ADDR: if (byte_vld) begin
          addr   <= {addr[AW-BYTE_W-1:0], byte_val};
          acnt_q <= acnt_q + 2'd1;
          if (acnt_q == 2'd3) begin
            dcnt_q <= '0;
            state  <= is_read_q ? ST_DUMMY : ST_PDATA;
          end
        end
        ST_DUMMY: begin
          dcnt_q <= dcnt_q + DCW'(1);
          if (last_dummy) state <= ST_RDATA;
          if (fetch) addr <= addr + AW'(1);
        end
        ST_RDATA: if (fetch) addr <= addr + AW'(1);
        ST_PDATA: if (byte_vld) begin
          addr[BYTE_W-1:0] <= addr[BYTE_W-1:0] + 8'd1;
        end
        ST_SKIP: ;
        default: state <= ST_OPC;
      endcase
    end
  end
endmodule

// File: rtl/sfl_slave.sv
// Top: serial memory slave with one- or eight-lane data width.
module sfl_slave
  import sfl_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int DUMMY_CLKS = 8
) (
  input  logic             sck,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [LANES-1:0] io_in,
  output logic [LANES-1:0] io_out,
  output logic [LANES-1:0] io_oe
);
  localparam int AW = $clog2(DEPTH);

  logic              byte_vld;
  logic [BYTE_W-1:0] byte_val;
  logic              fetch;
  sfl_state_e        state;
  logic              octal;
  logic              wel;
  logic [AW-1:0]     addr;
  logic              mem_we;
  logic              load;
  logic              active;
  logic [BYTE_W-1:0] rd_byte;

  sfl_lane_rx u_rx (
    .clk(sck), .rst_n(rst_n), .cs_n(cs_n), .octal(octal), .io_in(io_in),
    .byte_vld(byte_vld), .byte_val(byte_val)
  );

  sfl_ctrl #(.DEPTH(DEPTH), .DUMMY_CLKS(DUMMY_CLKS)) u_ctrl (
    .clk(sck), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld), .byte_val(byte_val),
    .fetch(fetch), .state(state), .octal(octal), .wel(wel), .addr(addr),
    .mem_we(mem_we), .load(load), .active(active)
  );

  sfl_store #(.DEPTH(DEPTH)) u_store (
    .clk(sck), .we(mem_we), .waddr(addr), .wdata(byte_val),
    .raddr(addr), .rdata(rd_byte)
  );

  sfl_lane_tx u_tx (
    .clk(sck), .rst_n(rst_n), .cs_n(cs_n), .octal(octal), .active(active),
    .load(load), .rd_byte(rd_byte), .fetch(fetch), .io_out(io_out), .io_oe(io_oe)
  );
endmodule

// File: rtl/sfl_checker.sv
module sfl_checker
  import sfl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic [LANES-1:0] io_oe,
  input logic             octal,
  input logic             wel,
  input sfl_state_e       state,
  input logic             mem_we
);
  p_oe_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> io_oe == '0);

  p_abort_to_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> state == ST_OPC);

  p_octal_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(octal) |-> $past(wel));

  p_write_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wel && !cs_n));

  p_single_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !octal |-> io_oe[LANES-1:1] == '0);

  p_width_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(octal) |-> $past(state) == ST_OPC);
endmodule

bind sfl_slave sfl_checker u_chk (
  .clk(sck), .rst_n(rst_n), .cs_n(cs_n), .io_oe(io_oe),
  .octal(octal), .wel(wel), .state(state), .mem_we(mem_we)
);

// File: tb/tb_sfl_slave.sv
module tb_sfl_slave;
  logic       sck = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic [7:0] io_oe;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   oct = 1'b0;
  bit   done = 1'b0;
  logic [7:0] rbuf [8];
  logic [7:0] pbuf [4];

  sfl_slave dut (.sck(sck), .rst_n(rst_n), .cs_n(cs_n), .io_in(io_in),
                 .io_out(io_out), .io_oe(io_oe));

  always #5 sck = ~sck;

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    if (oct) begin
      @(negedge sck); cs_n = 1'b0; io_in = b;
    end else begin
      for (int i = 7; i >= 0; i--) begin
        @(negedge sck); cs_n = 1'b0; io_in = {7'b0, b[i]};
      end
    end
  endtask

  task automatic end_frame();
    @(negedge sck); cs_n = 1'b1; io_in = 8'h00;
  endtask

  task automatic put_addr(input logic [31:0] a);
    for (int i = 3; i >= 0; i--) put_byte(a[i*8 +: 8]);
  endtask

  task automatic cmd1(input logic [7:0] op);
    put_byte(op);
    end_frame();
  endtask

  task automatic program_bytes(input logic [31:0] a, input int n);
    put_byte(8'h02);
    put_addr(a);
    for (int i = 0; i < n; i++) put_byte(pbuf[i]);
    end_frame();
  endtask

  // Read n bytes; checks the lane enables on each byte (R7, R10).
  task automatic read_bytes(input logic [31:0] a, input int n, input bit close);
    logic [7:0] b;
    put_byte(8'h03);
    put_addr(a);
    repeat (8) begin
      @(negedge sck); cs_n = 1'b0; io_in = 8'h00;
    end
    for (int k = 0; k < n; k++) begin
      if (oct) begin
        @(negedge sck);
        b = io_out;
        check_eq("R7 octal oe", {24'b0, io_oe}, 32'hFF);
      end else begin
        for (int i = 0; i < 8; i++) begin
          @(negedge sck);
          b = {b[6:0], io_out[0]};
          if (i == 0) check_eq("R10 single-lane oe", {24'b0, io_oe}, 32'h01);
        end
      end
      rbuf[k] = b;
    end
    if (close) end_frame();
  endtask

  task automatic t_reset();
    @(negedge sck);
    check_eq("R1 oe after reset", {24'b0, io_oe}, 32'h0);
  endtask

  task automatic t_program_single();
    cmd1(8'h06);
    pbuf[0] = 8'h11; pbuf[1] = 8'h22; pbuf[2] = 8'h33;
    program_bytes(32'h0000_03FE, 3);
    cmd1(8'h06);
    pbuf[0] = 8'h44; pbuf[1] = 8'h55;
    program_bytes(32'h0000_0000, 2);
    read_bytes(32'h0000_03FE, 4, 1'b1);
    check_eq("R5 byte 0x3FE", {24'b0, rbuf[0]}, 32'h11);
    check_eq("R7 byte 0x3FF", {24'b0, rbuf[1]}, 32'h22);
    check_eq("R8 wrap to 0x000", {24'b0, rbuf[2]}, 32'h44);
    check_eq("R8 stream 0x001", {24'b0, rbuf[3]}, 32'h55);
    read_bytes(32'hFF00_0300, 1, 1'b1);
    check_eq("R5 page wrap 0x300 (R8 high bits ignored)", {24'b0, rbuf[0]}, 32'h33);
    check_eq("R3 single-lane width kept", {31'b0, oct}, 32'h0);
  endtask

  task automatic t_no_latch();
    pbuf[0] = 8'h99;
    program_bytes(32'h0000_03FE, 1);
    read_bytes(32'h0000_03FE, 1, 1'b1);
    check_eq("R6 latch cleared, R5 no write", {24'b0, rbuf[0]}, 32'h11);
  endtask

  task automatic t_unknown();
    put_byte(8'h5A);
    put_byte(8'h06);
    end_frame();
    pbuf[0] = 8'h77;
    program_bytes(32'h0000_0000, 1);
    read_bytes(32'h0000_0000, 1, 1'b1);
    check_eq("R11 unknown opcode ignored", {24'b0, rbuf[0]}, 32'h44);
  endtask

  task automatic t_abort();
    cmd1(8'h06);
    put_byte(8'h02);
    put_byte(8'h00);
    put_byte(8'h00);
    end_frame();
    read_bytes(32'h0000_03FF, 2, 1'b0);
    check_eq("R2 fresh opcode after abort", {24'b0, rbuf[0]}, 32'h22);
    check_eq("R8 stream after abort", {24'b0, rbuf[1]}, 32'h44);
    @(negedge sck); cs_n = 1'b1;
    #1;
    check_eq("R2 oe released with cs high", {24'b0, io_oe}, 32'h0);
    pbuf[0] = 8'h66;
    program_bytes(32'h0000_03FE, 1);
    read_bytes(32'h0000_03FE, 1, 1'b1);
    check_eq("R6 latch cleared by aborted program", {24'b0, rbuf[0]}, 32'h11);
  endtask

  task automatic t_octal_no_latch();
    cmd1(8'hE8);
    read_bytes(32'h0000_03FE, 1, 1'b1);
    check_eq("R4 width unchanged without latch", {24'b0, rbuf[0]}, 32'h11);
  endtask

  task automatic t_octal();
    cmd1(8'h06);
    cmd1(8'hE8);
    oct = 1'b1;
    read_bytes(32'h0000_03FE, 4, 1'b1);
    check_eq("R4 octal read 0x3FE", {24'b0, rbuf[0]}, 32'h11);
    check_eq("R7 octal read 0x3FF", {24'b0, rbuf[1]}, 32'h22);
    check_eq("R8 octal wrap", {24'b0, rbuf[2]}, 32'h44);
    check_eq("R8 octal stream", {24'b0, rbuf[3]}, 32'h55);
    cmd1(8'h06);
    pbuf[0] = 8'hA5; pbuf[1] = 8'h5A;
    program_bytes(32'h0000_03FF, 2);
    read_bytes(32'h0000_03FF, 2, 1'b1);
    check_eq("R5 octal program 0x3FF", {24'b0, rbuf[0]}, 32'hA5);
    check_eq("R8 octal wrap after program", {24'b0, rbuf[1]}, 32'h44);
    read_bytes(32'h0000_0300, 1, 1'b1);
    check_eq("R5 octal page wrap 0x300", {24'b0, rbuf[0]}, 32'h5A);
  endtask

  task automatic t_swreset();
    cmd1(8'h06);
    cmd1(8'h99);
    oct = 1'b0;
    pbuf[0] = 8'hEE;
    program_bytes(32'h0000_0000, 1);
    read_bytes(32'h0000_0000, 1, 1'b1);
    check_eq("R9 single-lane again and latch cleared", {24'b0, rbuf[0]}, 32'h44);
  endtask

  initial begin
    repeat (3) @(negedge sck);
    rst_n = 1'b1;
    t_reset();
    t_program_single();
    t_no_latch();
    t_unknown();
    t_abort();
    t_octal_no_latch();
    t_octal();
    t_swreset();
    repeat (4) @(negedge sck);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge sck);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule